// File: doc/BRIEF.md
# Serial DAC Chain Write Controller

This block is the host end of a three-wire serial link to a chain of 10-bit voltage-output DACs. The DACs are wired in cascade: the host data line feeds the first DAC, each DAC's echo output feeds the next one, and the echo of the farthest DAC returns to the host. Client logic hands the block one code per DAC over a valid/ready handshake. The first code accepted is for the nearest DAC. Once the batch is complete, the block drops chip select and clocks out one 16-bit frame per DAC in a single chip-select window. The frame for the farthest DAC goes out first, so every DAC holds its own frame when chip select rises. Each frame is four leading zero bits, then the code with its most significant bit first, then two trailing zero bits. The clock idles low and data is sampled on rising edges (mode 0).

A controller with six states drives the link. COLLECT accepts codes. Accepting the last code of a batch moves it to SETUP, where chip select is low and the clock is low. SETUP goes to HIGH. HIGH goes to LOW while bits remain and to HOLD after the last bit. LOW goes back to HIGH. HOLD keeps the clock low before chip select rises and moves to GAP. GAP holds chip select high for the minimum time and returns to COLLECT. Each clock phase lasts `DIV` system cycles. The data line changes only as the clock falls, which gives a full half-period of setup before each rising edge.

When readback is enabled, the block samples the returning echo line at each rising edge. Because the DACs shift out what they held, a window returns the stream sent in the previous window. The block compares the two streams and raises a sticky error on any mismatch.

Top module: `dac_chain_host`

## Requirements
- R1: While reset is held and just after it, cs_n is 1, sclk is 0, din is 0, in_ready is 1 and rb_err is 0.
- R2: After the in_valid/in_ready handshake that completes a batch of N codes, in_ready stays low for exactly 32·N·DIV + DIV + GAP_CYC system cycles, and it is low whenever cs_n is low.
- R3: sclk is 0 whenever cs_n is 1. cs_n changes only on a cycle where sclk is 0 both before and after the change.
- R4: Every sclk high phase lasts exactly DIV cycles. Every sclk low phase inside a chip-select window, including the one before the first rise, lasts exactly DIV cycles. One window holds exactly 16·N rising edges.
- R5: Each 16-bit frame is sent most significant bit first: bits 15..12 are 0, bits 11..2 carry the code (bit 11 is code bit 9), and bits 1..0 are 0.
- R6: The k-th code accepted in a batch (k = 0 first) ends up in the DAC at position k counted from the host. The frame for position N-1 is sent first.
- R7: din never changes on a cycle where sclk is 1, so it is stable for at least DIV cycles before each rising edge.
- R8: cs_n stays 1 for at least GAP_CYC cycles between two chip-select windows.
- R9: When rb_en is 1 and the previous window used the same chain length, each dout bit sampled at a rising edge is compared with the matching bit of the previous window's stream. Any mismatch sets rb_err, which stays 1 until reset.
- R10: No comparison is made in the first window after reset, in a window whose chain length differs from the previous one, or when rb_en is 0. In those windows a wrong dout leaves rb_err unchanged.
- R11: The chain length (chain_len_m1 + 1, field value 0..7 meaning 1..8 devices) is taken with the first code of a batch. Later changes during that batch have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chain_len_m1 | input | 3 | Number of cascaded DACs minus one |
| rb_en | input | 1 | Enables comparison of the returned echo stream |
| in_valid | input | 1 | Code offered by the client |
| in_code | input | 10 | DAC code for the next chain position |
| in_ready | output | 1 | Block can accept a code |
| cs_n | output | 1 | Active-low chip select to the chain |
| sclk | output | 1 | Serial clock, idles low |
| din | output | 1 | Serial data to the nearest DAC |
| dout | input | 1 | Echo returned by the farthest DAC |
| rb_err | output | 1 | Sticky echo-mismatch flag |

## Verification
The ready-low window is due at the first falling system-clock edge after the accepting edge and lasts exactly 32·N·DIV + DIV + GAP_CYC cycles. The bench counts it on falling edges and compares the count with that formula. Device contents and rb_err are due once in_ready has returned, which is GAP_CYC cycles after chip select rises, so the bench reads the behavioural DAC chain model and the flag only at that point. The phase lengths, clock-idle rules and data stability are checked cycle by cycle on falling system-clock edges, where every output registered at the rising edge has already settled.

// File: rtl/dch_pkg.sv
package dch_pkg;

    typedef enum logic [2:0] {
        ST_COLLECT,
        ST_SETUP,
        ST_HIGH,
        ST_LOW,
        ST_HOLD,
        ST_GAP
    } dch_state_e;

    // Bits needed to index n items (at least one).
    function automatic int dch_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/dch_timer.sv
module dch_timer #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/dch_frame_stack.sv
module dch_frame_stack #(
    parameter int MAX_DEV = 8,
    parameter int CODE_W  = 10,
    parameter int PAD_HI  = 4,
    parameter int PAD_LO  = 2
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       push,
    input  logic [CODE_W-1:0]                          code,
    input  logic                                       shift,
    output logic [MAX_DEV*(PAD_HI+CODE_W+PAD_LO)-1:0]  stream,
    output logic                                       msb
);
    localparam int FRAME_W  = PAD_HI + CODE_W + PAD_LO;
    localparam int STREAM_W = MAX_DEV * FRAME_W;

    logic [FRAME_W-1:0]  frame;
    logic [STREAM_W-1:0] sr;

    assign frame = {{PAD_HI{1'b0}}, code, {PAD_LO{1'b0}}};

    // New frames enter at the top, so the newest (farthest) leaves first.
    generate
        if (MAX_DEV == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sr <= '0;
                end else if (push) begin
                    sr <= frame;
                end else if (shift) begin
                    sr <= {sr[STREAM_W-2:0], 1'b0};
                end
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sr <= '0;
                end else if (push) begin
                    sr <= {frame, sr[STREAM_W-1:FRAME_W]};
                end else if (shift) begin
                    sr <= {sr[STREAM_W-2:0], 1'b0};
                end
            end
        end
    endgenerate

    assign stream = sr;
    assign msb    = sr[STREAM_W-1];
endmodule

// File: rtl/dch_echo_chk.sv
module dch_echo_chk #(
    parameter int STREAM_W = 128,
    parameter int NW       = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                capture,
    input  logic                sample,
    input  logic [STREAM_W-1:0] stream,
    input  logic [NW-1:0]       len_m1,
    input  logic                rb_en,
    input  logic                dout,
    output logic                err
);
    logic [STREAM_W-1:0] prev_sr;
    logic [STREAM_W-1:0] cmp_sr;
    logic                prev_vld;
    logic [NW-1:0]       prev_len;
    logic                chk_on;
    logic                chk_now;

    assign chk_now = rb_en && prev_vld && (prev_len == len_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_sr  <= '0;
            cmp_sr   <= '0;
            prev_vld <= 1'b0;
            prev_len <= '0;
            chk_on   <= 1'b0;
            err      <= 1'b0;
        end else if (capture) begin
            // First rising edge of a window: swap in the new stream.
            prev_sr  <= stream;
            prev_vld <= 1'b1;
            prev_len <= len_m1;
            chk_on   <= chk_now;
            cmp_sr   <= {prev_sr[STREAM_W-2:0], 1'b0};
            if (chk_now && (dout != prev_sr[STREAM_W-1])) begin
                err <= 1'b1;
            end
        end else if (sample) begin
            cmp_sr <= {cmp_sr[STREAM_W-2:0], 1'b0};
            if (chk_on && (dout != cmp_sr[STREAM_W-1])) begin
                err <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/dac_chain_host.sv
module dac_chain_host
    import dch_pkg::*;
#(
    parameter int MAX_DEV = 8,
    parameter int CODE_W  = 10,
    parameter int PAD_HI  = 4,
    parameter int PAD_LO  = 2,
    parameter int DIV     = 3,
    parameter int GAP_CYC = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [dch_bits(MAX_DEV)-1:0]  chain_len_m1,
    input  logic                          rb_en,
    input  logic                          in_valid,
    input  logic [CODE_W-1:0]             in_code,
    output logic                          in_ready,
    output logic                          cs_n,
    output logic                          sclk,
    output logic                          din,
    input  logic                          dout,
    output logic                          rb_err
);
    localparam int NW       = dch_bits(MAX_DEV);
    localparam int FRAME_W  = PAD_HI + CODE_W + PAD_LO;
    localparam int STREAM_W = MAX_DEV * FRAME_W;
    localparam int BCW      = dch_bits(STREAM_W);
    localparam int TMAX     = (DIV > GAP_CYC) ? DIV : GAP_CYC;
    localparam int TW       = dch_bits(TMAX + 1);

    dch_state_e state, state_nxt;

    logic [NW-1:0]       cnt;
    logic [NW-1:0]       n_lat;
    logic [NW-1:0]       n_eff;
    logic [BCW-1:0]      bits_left;
    logic                push;
    logic                last_code;
    logic                tmr_load;
    logic [TW-1:0]       tmr_val;
    logic                tmr_done;
    logic                stk_shift;
    logic                first_rise;
    logic                next_rise;
    logic [STREAM_W-1:0] stream;
    logic                stk_msb;
    logic                cs_n_q, sclk_q, ready_q;

    assign n_eff      = (cnt == '0) ? chain_len_m1 : n_lat;
    assign push       = in_valid && ready_q;
    assign last_code  = push && (cnt == n_eff);
    assign tmr_load   = (state_nxt != state);
    assign tmr_val    = (state_nxt == ST_GAP) ? TW'(GAP_CYC - 1) : TW'(DIV - 1);
    assign stk_shift  = (state == ST_HIGH) && (state_nxt == ST_LOW);
    assign first_rise = (state == ST_SETUP) && (state_nxt == ST_HIGH);
    assign next_rise  = (state == ST_LOW) && (state_nxt == ST_HIGH);

    dch_timer #(.W(TW)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .val   (tmr_val),
        .done  (tmr_done)
    );

    dch_frame_stack #(
        .MAX_DEV (MAX_DEV),
        .CODE_W  (CODE_W),
        .PAD_HI  (PAD_HI),
        .PAD_LO  (PAD_LO)
    ) u_stack (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (push),
        .code   (in_code),
        .shift  (stk_shift),
        .stream (stream),
        .msb    (stk_msb)
    );

    dch_echo_chk #(
        .STREAM_W (STREAM_W),
        .NW       (NW)
    ) u_echo (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (first_rise),
        .sample  (next_rise),
        .stream  (stream),
        .len_m1  (n_lat),
        .rb_en   (rb_en),
        .dout    (dout),
        .err     (rb_err)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_COLLECT;
        end else begin
            state <= state_nxt;
        end
    end

    // Next-state decode
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_COLLECT: if (last_code) state_nxt = ST_SETUP;
            ST_SETUP:   if (tmr_done)  state_nxt = ST_HIGH;
            ST_HIGH:    if (tmr_done)  state_nxt = (bits_left == '0) ? ST_HOLD : ST_LOW;
            ST_LOW:     if (tmr_done)  state_nxt = ST_HIGH;
            ST_HOLD:    if (tmr_done)  state_nxt = ST_GAP;
            ST_GAP:     if (tmr_done)  state_nxt = ST_COLLECT;
            default:                   state_nxt = ST_COLLECT;
        endcase
    end

    // Batch and bit counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            n_lat     <= '0;
            bits_left <= '0;
        end else begin
            if (push) begin
                cnt <= last_code ? '0 : cnt + 1'b1;
                if (cnt == '0) begin
                    n_lat <= chain_len_m1;
                end
            end
            if (last_code) begin
                bits_left <= BCW'((int'(n_eff) + 1) * FRAME_W - 1);
            end else if (stk_shift) begin
                bits_left <= bits_left - 1'b1;
            end
        end
    end

    // Registered link outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n_q  <= 1'b1;
            sclk_q  <= 1'b0;
            ready_q <= 1'b1;
        end else begin
            cs_n_q  <= (state_nxt == ST_COLLECT) || (state_nxt == ST_GAP);
            sclk_q  <= (state_nxt == ST_HIGH);
            ready_q <= (state_nxt == ST_COLLECT);
        end
    end

    assign cs_n     = cs_n_q;
    assign sclk     = sclk_q;
    assign in_ready = ready_q;
    assign din      = stk_msb;
endmodule

// File: rtl/dac_chain_host_sva.sv
module dac_chain_host_sva #(
    parameter int DIV     = 3,
    parameter int GAP_CYC = 2
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sclk,
    input logic din,
    input logic in_ready,
    input logic rb_err
);
    logic [15:0] hi_len;
    logic [15:0] lo_len;
    logic [15:0] gap_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_len  <= '0;
            lo_len  <= '0;
            gap_len <= '1;
        end else begin
            hi_len  <= sclk ? hi_len + 1'b1 : '0;
            lo_len  <= (cs_n || sclk) ? '0 : lo_len + 1'b1;
            if (!cs_n) begin
                gap_len <= '0;
            end else if (gap_len != '1) begin
                gap_len <= gap_len + 1'b1;
            end
        end
    end

    assert_clk_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    assert_cs_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n != $past(cs_n)) |-> (!sclk && !$past(sclk)));

    assert_high_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> (hi_len == 16'(DIV)));

    assert_low_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> (lo_len == 16'(DIV)));

    assert_din_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(din));

    assert_cs_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (gap_len >= 16'(GAP_CYC)));

    assert_busy_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> !in_ready);

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rb_err) |-> rb_err);
endmodule

bind dac_chain_host dac_chain_host_sva #(
    .DIV     (DIV),
    .GAP_CYC (GAP_CYC)
) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sclk     (sclk),
    .din      (din),
    .in_ready (in_ready),
    .rb_err   (rb_err)
);

// File: tb/sim_dac_chain_host.sv
module sim_dac_chain_host;
    localparam int DIV = 3;
    localparam int GAP = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] chain_len_m1 = '0;
    logic       rb_en = 1'b0;
    logic       in_valid = 1'b0;
    logic [9:0] in_code = '0;
    logic       in_ready, cs_n, sclk, din, dout, rb_err;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    dac_chain_host #(.DIV(DIV), .GAP_CYC(GAP)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .chain_len_m1 (chain_len_m1),
        .rb_en        (rb_en),
        .in_valid     (in_valid),
        .in_code      (in_code),
        .in_ready     (in_ready),
        .cs_n         (cs_n),
        .sclk         (sclk),
        .din          (din),
        .dout         (dout),
        .rb_err       (rb_err)
    );

    // Behavioural DAC chain: shift on rise, echo on fall, latch on cs rise
    logic [15:0] msr  [8] = '{default: '0};
    logic        mdo  [8] = '{default: 1'b0};
    logic [9:0]  mlat [8] = '{default: '0};
    logic [2:0]  mn_m1 = '0;
    logic        inj = 1'b0;
    int          rise_cnt = 0;

    always @(posedge sclk) begin
        if (!cs_n) begin
            rise_cnt = rise_cnt + 1;
            for (int k = 0; k < 8; k++) begin
                msr[k] <= {msr[k][14:0], (k == 0) ? din : mdo[(k == 0) ? 0 : k - 1]};
            end
        end
    end

    always @(negedge sclk) begin
        if (!cs_n) begin
            for (int k = 0; k < 8; k++) mdo[k] <= msr[k][15];
        end
    end

    always @(posedge cs_n) begin
        for (int k = 0; k < 8; k++) mlat[k] <= msr[k][11:2];
    end

    assign dout = mdo[mn_m1] ^ inj;

    // Cycle monitors, sampled away from the active edge
    int  viol_idle = 0;
    int  viol_din  = 0;
    int  hi_run    = 0;
    int  min_gap   = 1000000;
    logic p_cs = 1'b1, p_sclk = 1'b0, p_din = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (cs_n && sclk) viol_idle++;
            if ((cs_n != p_cs) && (sclk || p_sclk)) viol_idle++;
            if (sclk && (din != p_din)) viol_din++;
            if (cs_n) hi_run++;
            else if (p_cs) begin
                if (hi_run < min_gap) min_gap = hi_run;
                hi_run = 0;
            end
        end
        p_cs = cs_n; p_sclk = sclk; p_din = din;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_low(input int n);
        return 32 * n * DIV + DIV + GAP;
    endfunction

    logic [9:0] cq [8];
    bit  have_prev = 0;
    int  prev_n    = 0;
    bit  err_exp   = 0;

    task automatic run_batch(input int n, input bit rb, input bit injv, input int alt);
        int lowc;
        string lreq;
        chain_len_m1 = 3'(n - 1);
        rb_en        = rb;
        inj          = injv;
        mn_m1        = 3'(n - 1);
        rise_cnt     = 0;
        for (int k = 0; k < n; k++) begin
            do @(negedge clk); while (!in_ready);
            in_valid = 1'b1;
            in_code  = cq[k];
            @(negedge clk);
            in_valid = 1'b0;
            if (k == 0 && alt >= 0) chain_len_m1 = 3'(alt);
        end
        lowc = 0;
        while (!in_ready) begin
            lowc++;
            @(negedge clk);
        end
        if (rb && have_prev && prev_n == n && injv) err_exp = 1;
        have_prev = 1;
        prev_n    = n;
        lreq = (alt >= 0) ? "R11" : "R6";
        chk(lowc == exp_low(n), (alt >= 0) ? "R11 ready-low" : "R2 ready-low", lowc, exp_low(n));
        chk(rise_cnt == 16 * n, "R4 rising edges", rise_cnt, 16 * n);
        for (int k = 0; k < n; k++) begin
            chk(mlat[k] == cq[k], lreq, int'(mlat[k]), int'(cq[k]));
            chk(msr[k][15:12] == 4'd0 && msr[k][1:0] == 2'd0, "R5 padding",
                int'(msr[k]), int'({4'd0, cq[k], 2'd0}));
        end
        chk(rb_err == err_exp, injv ? "R9 rb_err" : "R10 rb_err", int'(rb_err), int'(err_exp));
        inj          = 1'b0;
        chain_len_m1 = 3'(n - 1);
    endtask

    initial begin
        repeat (1500000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(cs_n == 1'b1 && sclk == 1'b0 && din == 1'b0, "R1 link idle",
            int'({cs_n, sclk, din}), 4);
        chk(in_ready == 1'b1 && rb_err == 1'b0, "R1 ready/err", int'({in_ready, rb_err}), 2);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n == 1'b1 && sclk == 1'b0 && in_ready == 1'b1, "R1 after release",
            int'({cs_n, sclk, in_ready}), 5);

        // R10: first window, nothing to compare against, wrong echo ignored
        cq[0] = 10'h2A5;
        run_batch(1, 1, 1, -1);
        // R9: same length, correct echo
        cq[0] = 10'h15A;
        run_batch(1, 1, 0, -1);
        // R10: length change, wrong echo ignored
        cq[0] = 10'h001; cq[1] = 10'h200; cq[2] = 10'h3FF;
        run_batch(3, 1, 1, -1);
        cq[0] = 10'h3FF; cq[1] = 10'h000; cq[2] = 10'h155;
        run_batch(3, 1, 0, -1);
        // Corner codes across a full chain
        for (int k = 0; k < 8; k++) cq[k] = 10'h3FF;
        run_batch(8, 1, 0, -1);
        for (int k = 0; k < 8; k++) cq[k] = 10'h000;
        run_batch(8, 1, 0, -1);
        // R10: readback disabled, wrong echo ignored
        for (int k = 0; k < 8; k++) cq[k] = 10'(k * 97);
        run_batch(8, 0, 1, -1);
        // R11: length changed after first code of a batch
        cq[0] = 10'h0F0; cq[1] = 10'h30F;
        run_batch(2, 0, 0, 6);
        // Random mix, echo always correct
        for (int b = 0; b < 12; b++) begin
            n = 1 + int'($urandom % 8);
            for (int k = 0; k < 8; k++) cq[k] = 10'($urandom);
            run_batch(n, 1'($urandom), 0, -1);
        end
        // R9: mismatch detected, then flag stays set
        n = prev_n;
        for (int k = 0; k < 8; k++) cq[k] = 10'($urandom);
        run_batch(n, 1, 1, -1);
        for (int k = 0; k < 8; k++) cq[k] = 10'($urandom);
        run_batch(n, 1, 0, -1);
        chk(rb_err == 1'b1, "R9 sticky", int'(rb_err), 1);

        chk(viol_idle == 0, "R3 clock idle around cs", viol_idle, 0);
        chk(viol_din == 0, "R7 din stable while sclk high", viol_din, 0);
        chk(min_gap >= GAP, "R8 cs high gap", min_gap, GAP);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule